// File: doc/BRIEF.md
# USB OUT Endpoint Control/Status Register

This block is the byte-wide control and status register of one USB device OUT endpoint. It sits between a processor byte bus and the endpoint's USB-side engine. Event inputs from the engine raise sticky status flags. The processor can clear those flags, hold the endpoint in stall, flush a pending packet out of the receive FIFO and force the data toggle back to DATA0. The processor only ever clears the flags; it can never set them.

The block also compares each received OUT packet's byte count against a maximum packet size supplied on an input port. An oversize packet raises a stall request towards the engine. The request stays up until the engine reports that the STALL handshake went out. At that point the "stall sent" flag is raised.

Every write replaces the whole register. Software must therefore use read-modify-write. It writes 1 to a flag bit that it wants to keep, and it writes the current value of the send-stall bit back.

Top module: `usb_out_ep_csr`

## Requirements
- R1: After a synchronous reset the register reads 0x00 and `stall_req`, `fifo_flush`, `toggle_clr` and `pkt_ready` are all low.
- R2: Bits 3, 2 and 1 and the command bits 7 and 4 always read as 0. Only bit 6 (stall sent), bit 5 (send stall) and bit 0 (packet ready) can read as 1.
- R3: A write whose bit 7 is 1 drives `toggle_clr` high for exactly the one cycle after the write edge. A write whose bit 7 is 0 produces no pulse.
- R4: Bit 6 is set by a `stall_sent_ev` cycle and cleared by a write whose bit 6 is 0. A write whose bit 6 is 1 leaves it unchanged.
- R5: Bit 5 takes the written value on every write. While bit 5 reads 1, `stall_req` is high.
- R6: A write with bit 4 = 1 while bit 0 is already 1 drives `fifo_flush` high for one cycle and clears bit 0 at the same edge. If bit 0 is 0, the flush write gives no pulse.
- R7: Bit 0 is set by a `pkt_loaded_ev` cycle and cleared by a write whose bit 0 is 0. A write whose bit 0 is 1 leaves it unchanged. `pkt_ready` always equals bit 0.
- R8: If a set event and a processor clear of the same flag fall in the same cycle, the flag ends up set.
- R9: A `rx_done` cycle with `rx_len` greater than `max_pkt_len` raises `stall_req` from the next cycle on, until a `stall_sent_ev` cycle ends it. A length equal to `max_pkt_len` does not count as oversize.
- R10: Writes and reads whose `cpu_addr` differs from the `CSR_ADDR` parameter change nothing, and such reads return 0x00.
- R11: `cpu_rdata` shows the register value as it stood before the read edge, in the cycle after `cpu_rd` at the register address. In every other cycle it is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Processor byte address |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rd | input | 1 | Processor read strobe |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Registered read data |
| pkt_loaded_ev | input | 1 | Engine has loaded a full packet into the FIFO |
| stall_sent_ev | input | 1 | Engine has finished an OUT transaction with STALL |
| rx_done | input | 1 | End of an OUT data packet; `rx_len` is valid |
| rx_len | input | CNT_W | Byte count of the packet just received |
| max_pkt_len | input | CNT_W | Maximum packet size of the endpoint |
| stall_req | output | 1 | Engine must answer with STALL |
| fifo_flush | output | 1 | One-cycle pulse that discards the pending packet |
| toggle_clr | output | 1 | One-cycle pulse that resets the data toggle to DATA0 |
| pkt_ready | output | 1 | Packet-ready flag state |

## Verification
The bench builds the block with a 7-bit length field and a non-default register address of 0x24. Random byte counts from 0 to 127 therefore land both below and above the maximum sizes picked at run time. They also hit the exact-equal boundary often. Random addresses fall on and off the decoded address, so ignored accesses occur often. Set events are sometimes given in the same cycles as clear writes and flush writes, which reaches the set-wins cases.

// File: rtl/usb_out_csr_pkg.sv
package usb_out_csr_pkg;
  localparam int CSR_W     = 8;
  localparam int BIT_TOG   = 7;
  localparam int BIT_SENT  = 6;
  localparam int BIT_SEND  = 5;
  localparam int BIT_FLUSH = 4;
  localparam int BIT_RDY   = 0;

  localparam int NUM_STICKY = 3;
  localparam int IDX_RDY    = 0;
  localparam int IDX_SENT   = 1;
  localparam int IDX_OVS    = 2;

  typedef struct packed {
    logic sent;
    logic send;
    logic rdy;
  } csr_view_t;

  function automatic logic [CSR_W-1:0] pack_view(input csr_view_t v);
    logic [CSR_W-1:0] b;
    b = '0;
    b[BIT_SENT] = v.sent;
    b[BIT_SEND] = v.send;
    b[BIT_RDY]  = v.rdy;
    return b;
  endfunction
endpackage

// File: rtl/csr_sticky_bit.sv
module csr_sticky_bit (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/csr_cmd_pulse.sv
module csr_cmd_pulse
  import usb_out_csr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [CSR_W-1:0] wdata,
  input  logic             rdy_q,
  output logic             flush_accept,
  output logic             flush_o,
  output logic             tog_o
);
  assign flush_accept = wr_hit && wdata[BIT_FLUSH] && rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_o <= 1'b0;
      tog_o   <= 1'b0;
    end else begin
      flush_o <= flush_accept;
      tog_o   <= wr_hit && wdata[BIT_TOG];
    end
  end
endmodule

// File: rtl/out_size_check.sv
module out_size_check #(
  parameter int CNT_W = 11
) (
  input  logic             rx_done,
  input  logic [CNT_W-1:0] rx_len,
  input  logic [CNT_W-1:0] max_len,
  output logic             oversize
);
  assign oversize = rx_done && (rx_len > max_len);
endmodule

// File: rtl/usb_out_ep_csr.sv
module usb_out_ep_csr
  import usb_out_csr_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              CNT_W    = 11,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [CSR_W-1:0]  cpu_wdata,
  output logic [CSR_W-1:0]  cpu_rdata,
  input  logic              pkt_loaded_ev,
  input  logic              stall_sent_ev,
  input  logic              rx_done,
  input  logic [CNT_W-1:0]  rx_len,
  input  logic [CNT_W-1:0]  max_pkt_len,
  output logic              stall_req,
  output logic              fifo_flush,
  output logic              toggle_clr,
  output logic              pkt_ready
);
  logic                  hit, wr_hit, rd_hit;
  logic                  flush_accept, oversize;
  logic                  send_q;
  logic [NUM_STICKY-1:0] set_v, clr_v, q_v;
  csr_view_t             view;

  assign hit    = (cpu_addr == CSR_ADDR);
  assign wr_hit = cpu_wr && hit;
  assign rd_hit = cpu_rd && hit;

  out_size_check #(.CNT_W(CNT_W)) u_size (
    .rx_done (rx_done),
    .rx_len  (rx_len),
    .max_len (max_pkt_len),
    .oversize(oversize)
  );

  csr_cmd_pulse u_cmd (
    .clk         (clk),
    .rst         (rst),
    .wr_hit      (wr_hit),
    .wdata       (cpu_wdata),
    .rdy_q       (q_v[IDX_RDY]),
    .flush_accept(flush_accept),
    .flush_o     (fifo_flush),
    .tog_o       (toggle_clr)
  );

  // set/clear sources for each sticky cell
  always_comb begin
    set_v           = '0;
    clr_v           = '0;
    set_v[IDX_RDY]  = pkt_loaded_ev;
    clr_v[IDX_RDY]  = (wr_hit && !cpu_wdata[BIT_RDY]) || flush_accept;
    set_v[IDX_SENT] = stall_sent_ev;
    clr_v[IDX_SENT] = wr_hit && !cpu_wdata[BIT_SENT];
    set_v[IDX_OVS]  = oversize;
    clr_v[IDX_OVS]  = stall_sent_ev;
  end

  for (genvar i = 0; i < NUM_STICKY; i++) begin : g_sticky
    csr_sticky_bit u_bit (
      .clk  (clk),
      .rst  (rst),
      .set_i(set_v[i]),
      .clr_i(clr_v[i]),
      .q_o  (q_v[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)         send_q <= 1'b0;
    else if (wr_hit) send_q <= cpu_wdata[BIT_SEND];
  end

  always_comb begin
    view.sent = q_v[IDX_SENT];
    view.send = send_q;
    view.rdy  = q_v[IDX_RDY];
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (rd_hit) cpu_rdata <= pack_view(view);
    else             cpu_rdata <= '0;
  end

  assign pkt_ready = q_v[IDX_RDY];
  assign stall_req = send_q || q_v[IDX_OVS];
endmodule

// File: rtl/usb_out_csr_chk.sv
module usb_out_csr_chk #(
  parameter int                ADDR_W   = 8,
  parameter int                CNT_W    = 11,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_wr,
  input logic              cpu_rd,
  input logic [7:0]        cpu_wdata,
  input logic [7:0]        cpu_rdata,
  input logic              pkt_loaded_ev,
  input logic              stall_sent_ev,
  input logic              rx_done,
  input logic [CNT_W-1:0]  rx_len,
  input logic [CNT_W-1:0]  max_pkt_len,
  input logic              stall_req,
  input logic              fifo_flush,
  input logic              toggle_clr,
  input logic              pkt_ready
);
  p_tog_from_write_r3: assert property (@(posedge clk) disable iff (rst)
    toggle_clr |-> $past(cpu_wr && cpu_addr == CSR_ADDR && cpu_wdata[7]));

  p_send_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == CSR_ADDR && cpu_wdata[5]) |=> stall_req);

  p_flush_needs_pkt_r6: assert property (@(posedge clk) disable iff (rst)
    fifo_flush |-> $past(pkt_ready));

  p_flush_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (fifo_flush && !$past(pkt_loaded_ev)) |-> !pkt_ready);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    pkt_loaded_ev |=> pkt_ready);

  p_oversize_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_len > max_pkt_len) |=> stall_req);

  p_rdata_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_rd && cpu_addr == CSR_ADDR) |-> cpu_rdata == 8'h00);
endmodule

bind usb_out_ep_csr usb_out_csr_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CSR_ADDR(CSR_ADDR)
) u_chk (.*);

// File: tb/sim_usb_out_ep_csr.sv
`timescale 1ns/1ps
module sim_usb_out_ep_csr;
  localparam int         AW  = 8;
  localparam int         CW  = 7;
  localparam logic [7:0] ADR = 8'h24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0]    cpu_wdata = '0;
  logic [7:0]    cpu_rdata;
  logic          pkt_loaded_ev = 1'b0, stall_sent_ev = 1'b0, rx_done = 1'b0;
  logic [CW-1:0] rx_len = '0, max_pkt_len = 7'd64;
  logic          stall_req, fifo_flush, toggle_clr, pkt_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit       m_rdy, m_send, m_sent, m_ovs, m_flush, m_tog;
  bit [7:0] m_rdata;

  always #2.5 clk = ~clk;

  usb_out_ep_csr #(.ADDR_W(AW), .CNT_W(CW), .CSR_ADDR(ADR)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit hit, wr, rd, facc;
    bit [7:0] view;
    if (rst) begin
      {m_rdy, m_send, m_sent, m_ovs, m_flush, m_tog} = '0;
      m_rdata = 8'h00;
      return;
    end
    hit  = (cpu_addr == ADR);
    wr   = cpu_wr && hit;
    rd   = cpu_rd && hit;
    facc = wr && cpu_wdata[4] && m_rdy;
    view = {1'b0, m_sent, m_send, 5'b00000} | {7'b0, m_rdy};
    m_rdata = rd ? view : 8'h00;
    m_flush = facc;
    m_tog   = wr && cpu_wdata[7];
    if (pkt_loaded_ev) m_rdy = 1;
    else if (wr && (!cpu_wdata[0] || facc)) m_rdy = 0;
    if (stall_sent_ev) m_sent = 1;
    else if (wr && !cpu_wdata[6]) m_sent = 0;
    if (wr) m_send = cpu_wdata[5];
    if (rx_done && (int'(rx_len) > int'(max_pkt_len))) m_ovs = 1;
    else if (stall_sent_ev) m_ovs = 0;
  endtask

  // one clock: inputs already driven; advance model; compare at negedge
  task automatic step();
    @(posedge clk);
    #0.5;
    model_update();
    @(negedge clk);
    chk("R11 rdata", cpu_rdata, m_rdata);
    chk("R5 stall_req", stall_req, int'(m_send || m_ovs));
    chk("R6 fifo_flush", fifo_flush, m_flush);
    chk("R3 toggle_clr", toggle_clr, m_tog);
    chk("R7 pkt_ready", pkt_ready, m_rdy);
  endtask

  task automatic idle();
    cpu_wr = 0; cpu_rd = 0; pkt_loaded_ev = 0; stall_sent_ev = 0; rx_done = 0;
    cpu_addr = ADR;
  endtask

  task automatic wr8(input logic [7:0] a, input logic [7:0] d);
    idle(); cpu_addr = a; cpu_wr = 1; cpu_wdata = d; step(); idle();
  endtask

  // read and check the returned byte one cycle later
  task automatic rd8(input string req, input logic [7:0] a, input logic [7:0] exp);
    idle(); cpu_addr = a; cpu_rd = 1; step(); idle();
    chk(req, cpu_rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; idle(); step(); step();
    rst = 0;
    // R1 reset state
    chk("R1 rst pkt_ready", pkt_ready, 0);
    chk("R1 rst stall_req", stall_req, 0);
    rd8("R1 reset value", ADR, 8'h00);

    // R7 set by event, write 1 no effect, write 0 clears
    idle(); pkt_loaded_ev = 1; step(); idle();
    rd8("R7 set", ADR, 8'h01);
    wr8(ADR, 8'h41);
    rd8("R7 write1 no effect", ADR, 8'h01);
    wr8(ADR, 8'h40);
    rd8("R7 write0 clears", ADR, 8'h00);

    // R4 stall sent flag
    idle(); stall_sent_ev = 1; step(); idle();
    rd8("R4 set", ADR, 8'h40);
    wr8(ADR, 8'h41);
    rd8("R4 write1 no effect", ADR, 8'h40);
    wr8(ADR, 8'h01);
    rd8("R4 write0 clears", ADR, 8'h00);

    // R5 send stall
    wr8(ADR, 8'h61);
    chk("R5 stall_req high", stall_req, 1);
    rd8("R5 readback", ADR, 8'h20);
    wr8(ADR, 8'h41);
    chk("R5 stall_req low", stall_req, 0);

    // R3 toggle clear pulse, one cycle only
    idle(); cpu_wr = 1; cpu_wdata = 8'hC1; step();
    chk("R3 pulse", toggle_clr, 1);
    idle(); step();
    chk("R3 pulse ends", toggle_clr, 0);

    // R6 flush without packet: no pulse
    wr8(ADR, 8'h51);
    chk("R6 no pkt no flush", fifo_flush, 0);
    idle(); pkt_loaded_ev = 1; step(); idle();
    wr8(ADR, 8'h51);
    chk("R6 flush pulse", fifo_flush, 1);
    chk("R6 flush clears bit0", pkt_ready, 0);

    // R8 set wins over clear
    idle(); pkt_loaded_ev = 1; cpu_wr = 1; cpu_wdata = 8'h40; step(); idle();
    chk("R8 rdy set wins", pkt_ready, 1);
    idle(); stall_sent_ev = 1; cpu_wr = 1; cpu_wdata = 8'h01; step(); idle();
    rd8("R8 sent set wins", ADR, 8'h41);
    wr8(ADR, 8'h00);

    // R2 reserved and command bits read 0
    idle(); pkt_loaded_ev = 1; step(); idle();
    wr8(ADR, 8'hEF);
    rd8("R2 read mask", ADR, 8'h21);
    wr8(ADR, 8'h41);

    // R9 oversize
    max_pkt_len = 7'd64;
    idle(); rx_done = 1; rx_len = 7'd64; step(); idle();
    chk("R9 equal not oversize", stall_req, 0);
    idle(); rx_done = 1; rx_len = 7'd65; step(); idle();
    chk("R9 oversize stall", stall_req, 1);
    step();
    chk("R9 held", stall_req, 1);
    idle(); stall_sent_ev = 1; step(); idle();
    chk("R9 released", stall_req, 0);
    rd8("R9 sent flag", ADR, 8'h41);

    // R10 other address ignored
    wr8(8'h25, 8'h20);
    chk("R10 write ignored", stall_req, 0);
    idle(); cpu_addr = 8'h25; cpu_rd = 1; step(); idle();
    chk("R10 read other zero", cpu_rdata, 0);
    wr8(8'h23, 8'h00);
    rd8("R10 state kept", ADR, 8'h41);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      cpu_addr      = ($urandom % 4 != 0) ? ADR : 8'($urandom);
      cpu_wr        = ($urandom % 3 == 0);
      cpu_rd        = ($urandom % 3 == 0);
      cpu_wdata     = 8'($urandom);
      pkt_loaded_ev = ($urandom % 5 == 0);
      stall_sent_ev = ($urandom % 7 == 0);
      rx_done       = ($urandom % 4 == 0);
      rx_len        = 7'($urandom);
      if (i % 64 == 0) max_pkt_len = 7'($urandom);
      if ($urandom % 6 == 0) rx_len = max_pkt_len;
      rst           = (i == 2000);
      step();
    end
    rst = 0; idle(); step();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule